// File: doc/BRIEF.md
# Terminal and Bypass Bin Decoder

This block is the terminal-and-bypass part of a binary arithmetic decoder. It holds the decoder state: a 9-bit interval width (range) and a 10-bit code value (offset). Each accepted request decodes one bin. A terminal request takes 2 off the range and compares the offset with the reduced range. A bypass request moves one fresh stream bit into the offset and compares the result with the unchanged range. Both modes use the same comparator.

Only one renormalization stage exists. A terminal bin of 0 that leaves the range below 256 uses it, taking in one stream bit on each step. A single skip-renormalization decision routes the range and offset through a pair of 2:1 multiplexers, so the stage is passed over in bypass mode and on a terminal bin of 1. The stream arrives serially with a ready/valid handshake. The decoder therefore stalls without losing state while no bit is offered. An initialise strobe loads a fresh range and offset before decoding starts.

Top module: `tbd_dec_top`

## Requirements
- R1: After reset the range reads 510 and the offset reads 0, `req_ready` is 1, and both `bin_valid` and `bit_ready` are 0.
- R2: When `init_valid` is high while the decoder is idle, the range and offset are loaded and show on `cur_range`/`cur_offset` from the next cycle. `req_ready` is 0 while `init_valid` is high. `init_valid` has no effect while a request is in progress.
- R3: A request with `req_mode`=1 is terminal. The range becomes range−2. If offset ≥ range−2, the bin is 1, the offset is unchanged, no stream bit is consumed, and `bin_valid` is high in the cycle after acceptance.
- R4: A terminal request with offset < range−2 gives bin 0 and range−2. If range−2 ≥ 256, no stream bit is consumed and `bin_valid` follows in the cycle after acceptance.
- R5: A terminal bin of 0 with range−2 < 256 is renormalized. Each accepted stream bit doubles the range and sets the offset to 2·offset+bit, until the range is ≥ 256. `bin_valid` is high in the cycle after the last bit.
- R6: A request with `req_mode`=0 is bypass. It consumes exactly one stream bit b and forms t = 2·offset+b. If t ≥ range, the bin is 1 and the offset becomes t−range. Otherwise the bin is 0 and the offset becomes t. The range is unchanged. `bin_valid` is high in the cycle after the bit is accepted.
- R7: `bit_ready` is high only while the decoder waits for a stream bit. While `bit_valid` is low, range, offset and progress hold, and the result is delayed by exactly the stalled cycles.
- R8: `bin_valid` is a one-cycle pulse, given once for each accepted request. `req_ready` is 0 from acceptance until the pulse ends and is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_valid | input | 1 | Load strobe for range and offset |
| init_range | input | 9 | Range value to load |
| init_offset | input | 10 | Offset value to load |
| req_valid | input | 1 | Bin request |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_mode | input | 1 | 1 = terminal, 0 = bypass |
| bit_valid | input | 1 | Stream bit offered |
| bit_ready | output | 1 | Decoder takes a stream bit this cycle when valid |
| bit_data | input | 1 | Stream bit |
| bin_valid | output | 1 | Decoded bin present |
| bin_value | output | 1 | Decoded bin |
| cur_range | output | 9 | Current range register |
| cur_offset | output | 10 | Current offset register |

## Verification
Assertions check several things on every cycle. The result pulse must last one cycle. Bypass must leave the range alone. Stalls must freeze the state. No stream bit may be requested while the decoder is idle. A terminal bin of 1 must appear at once. Renormalization steps must double the range. Only the bench scenarios can show the numbers themselves: the exact bin and offset for boundary cases such as offset equal to the reduced range or to the range. They also show the one-bit renormalization from ranges 256 and 257, the latency counted against stalls, an initialise strobe ignored mid-request, and offsets carried correctly across back-to-back bypass bins.

// File: rtl/tbd_pkg.sv
// Shared types for the terminal/bypass bin decoder.
// Assumes: one request in flight at a time.
package tbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BYPBIT = 2'd1,
        ST_RENORM = 2'd2,
        ST_EMIT   = 2'd3
    } tbd_state_e;

    localparam logic MODE_BYPASS = 1'b0;
    localparam logic MODE_TERM   = 1'b1;
endpackage

// File: rtl/tbd_cmp.sv
// Shared magnitude comparator and subtractor.
// Compares a (wide) against b (narrow, zero-extended) and gives a-b.
// Assumes: the caller ignores diff when ge is low.
module tbd_cmp #(
    parameter int A_W = 10,
    parameter int B_W = 9
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           ge,
    output logic [A_W-1:0] diff
);
    localparam int PAD_W = A_W - B_W;

    logic [A_W-1:0] b_ext;

    // Widen b to the compare width.
    always_comb begin
        b_ext = {{PAD_W{1'b0}}, b};
    end

    // One comparison and the matching difference.
    always_comb begin
        ge   = (a >= b_ext);
        diff = a - b_ext;
    end
endmodule

// File: rtl/tbd_renorm_step.sv
// One renormalization step: the range doubles and the offset shifts
// left, taking the next stream bit as its LSB.
// Assumes: the offset MSB is zero whenever a step is applied.
module tbd_renorm_step #(
    parameter int RANGE_W = 9,
    parameter int OFFS_W  = 10
) (
    input  logic [RANGE_W-1:0] range_in,
    input  logic [OFFS_W-1:0]  offs_in,
    input  logic               stream_bit,
    output logic [RANGE_W-1:0] range_out,
    output logic [OFFS_W-1:0]  offs_out,
    output logic               norm_done
);
    // Shift both state values by one position.
    always_comb begin
        range_out = {range_in[RANGE_W-2:0], 1'b0};
        offs_out  = {offs_in[OFFS_W-2:0], stream_bit};
        norm_done = range_out[RANGE_W-1];
    end
endmodule

// File: rtl/tbd_skip_mux.sv
// 2:1 selector between the decision value and the renormalized value.
// Assumes: take_pre is high whenever renormalization is passed over.
module tbd_skip_mux #(
    parameter int W = 9
) (
    input  logic         take_pre,
    input  logic [W-1:0] pre_val,
    input  logic [W-1:0] ren_val,
    output logic [W-1:0] y
);
    // Choose the source for the next register value.
    always_comb begin
        y = take_pre ? pre_val : ren_val;
    end
endmodule

// File: rtl/tbd_dec_top.sv
// Terminal/bypass bin decoder: holds range and offset, decodes one bin per
// request, and renormalizes from a serial stream with ready/valid stalls.
// Assumes: init values are normalized (range MSB set, offset < range).
module tbd_dec_top
    import tbd_pkg::*;
#(
    parameter int RANGE_W   = 9,
    parameter int OFFS_W    = 10,
    parameter int TERM_DEC  = 2,
    parameter int RST_RANGE = 510
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_valid,
    input  logic [RANGE_W-1:0] init_range,
    input  logic [OFFS_W-1:0]  init_offset,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_mode,
    input  logic               bit_valid,
    output logic               bit_ready,
    input  logic               bit_data,
    output logic               bin_valid,
    output logic               bin_value,
    output logic [RANGE_W-1:0] cur_range,
    output logic [OFFS_W-1:0]  cur_offset
);
    localparam logic [RANGE_W-1:0] DEC_V   = RANGE_W'(TERM_DEC);
    localparam logic [RANGE_W-1:0] RST_V   = RANGE_W'(RST_RANGE);
    localparam int                 MSB     = RANGE_W - 1;

    tbd_state_e         state_q, state_d;
    logic [RANGE_W-1:0] range_q, term_range, pre_range, ren_range, nxt_range;
    logic [OFFS_W-1:0]  offs_q, byp_offs, pre_offs, ren_offs, nxt_offs;
    logic [OFFS_W-1:0]  cmp_a, cmp_diff;
    logic [RANGE_W-1:0] cmp_b;
    logic               cmp_ge, bin_q, ren_done;
    logic               req_fire, bit_fire, in_byp, in_ren, skip_renorm;

    // Handshake decode.
    always_comb begin
        req_ready = (state_q == ST_IDLE) && !init_valid;
        bit_ready = (state_q == ST_BYPBIT) || (state_q == ST_RENORM);
        req_fire  = req_valid && req_ready;
        bit_fire  = bit_valid && bit_ready;
        in_byp    = (state_q == ST_BYPBIT);
        in_ren    = (state_q == ST_RENORM);
    end

    // Operand steering into the shared comparator.
    always_comb begin
        term_range = range_q - DEC_V;
        byp_offs   = {offs_q[OFFS_W-2:0], bit_data};
        cmp_a      = in_byp ? byp_offs : offs_q;
        cmp_b      = in_byp ? range_q : term_range;
    end

    tbd_cmp #(.A_W(OFFS_W), .B_W(RANGE_W)) u_cmp (
        .a    (cmp_a),
        .b    (cmp_b),
        .ge   (cmp_ge),
        .diff (cmp_diff)
    );

    // Decision values and the skip-renormalization control.
    always_comb begin
        skip_renorm = in_byp ||
                      ((state_q == ST_IDLE) && (req_mode == MODE_TERM) && cmp_ge);
        pre_range   = in_byp ? range_q : term_range;
        pre_offs    = in_byp ? (cmp_ge ? cmp_diff : byp_offs) : offs_q;
    end

    tbd_renorm_step #(.RANGE_W(RANGE_W), .OFFS_W(OFFS_W)) u_renorm (
        .range_in   (range_q),
        .offs_in    (offs_q),
        .stream_bit (bit_data),
        .range_out  (ren_range),
        .offs_out   (ren_offs),
        .norm_done  (ren_done)
    );

    tbd_skip_mux #(.W(RANGE_W)) u_mux_range (
        .take_pre (!in_ren),
        .pre_val  (pre_range),
        .ren_val  (ren_range),
        .y        (nxt_range)
    );

    tbd_skip_mux #(.W(OFFS_W)) u_mux_offs (
        .take_pre (!in_ren),
        .pre_val  (pre_offs),
        .ren_val  (ren_offs),
        .y        (nxt_offs)
    );

    // Next-state logic of the request sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    if (req_mode == MODE_BYPASS) begin
                        state_d = ST_BYPBIT;
                    end else if (skip_renorm || term_range[MSB]) begin
                        state_d = ST_EMIT;
                    end else begin
                        state_d = ST_RENORM;
                    end
                end
            end
            ST_BYPBIT: if (bit_fire) state_d = ST_EMIT;
            ST_RENORM: if (bit_fire && ren_done) state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Range, offset and bin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= RST_V;
            offs_q  <= '0;
            bin_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (init_valid) begin
                        range_q <= init_range;
                        offs_q  <= init_offset;
                    end else if (req_fire && (req_mode == MODE_TERM)) begin
                        range_q <= nxt_range;
                        offs_q  <= nxt_offs;
                        bin_q   <= cmp_ge;
                    end
                end
                ST_BYPBIT: begin
                    if (bit_fire) begin
                        range_q <= nxt_range;
                        offs_q  <= nxt_offs;
                        bin_q   <= cmp_ge;
                    end
                end
                ST_RENORM: begin
                    if (bit_fire) begin
                        range_q <= nxt_range;
                        offs_q  <= nxt_offs;
                    end
                end
                default: begin
                    range_q <= range_q;
                end
            endcase
        end
    end

    // Output drive.
    always_comb begin
        bin_valid  = (state_q == ST_EMIT);
        bin_value  = bin_q;
        cur_range  = range_q;
        cur_offset = offs_q;
    end

    AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n) bin_valid |=> !bin_valid); // R8
    AST_BYP_RANGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) in_byp |=> $stable(range_q)); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bit_ready && !bit_valid) |=> ($stable(range_q) && $stable(offs_q) && $stable(state_q))); // R7
    AST_NO_BIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !bit_ready); // R7
    AST_TERM_ONE_NOW: assert property (@(posedge clk) disable iff (!rst_n) (req_fire && (req_mode == MODE_TERM) && skip_renorm) |=> (bin_valid && bin_value)); // R3
    AST_RENORM_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n) (in_ren && bit_fire) |=> (range_q == {$past(range_q[RANGE_W-2:0]), 1'b0})); // R5
endmodule

// File: tb/tbd_dec_top_tb.sv
module tbd_dec_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {mode, range[8:0], offset[9:0], stream bit}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 9'd300, 10'd298, 1'b0},
        {1'b1, 9'd300, 10'd100, 1'b1},
        {1'b1, 9'd256, 10'd10,  1'b1},
        {1'b1, 9'd257, 10'd0,   1'b0},
        {1'b1, 9'd257, 10'd255, 1'b1},
        {1'b1, 9'd510, 10'd508, 1'b0},
        {1'b0, 9'd300, 10'd149, 1'b1},
        {1'b0, 9'd300, 10'd150, 1'b0},
        {1'b0, 9'd510, 10'd509, 1'b1},
        {1'b0, 9'd256, 10'd0,   1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_valid = 1'b0;
    logic [8:0] init_range = '0;
    logic [9:0] init_offset = '0;
    logic req_valid = 1'b0, req_mode = 1'b0;
    logic bit_valid = 1'b0, bit_data = 1'b0;
    logic req_ready, bit_ready, bin_valid, bin_value;
    logic [8:0] cur_range;
    logic [9:0] cur_offset;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbd_dec_top u_dut (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_range(init_range),
        .init_offset(init_offset), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .bit_valid(bit_valid), .bit_ready(bit_ready),
        .bit_data(bit_data), .bin_valid(bin_valid), .bin_value(bin_value),
        .cur_range(cur_range), .cur_offset(cur_offset)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input int r, input int o);
        @(negedge clk);
        init_valid = 1'b1; init_range = 9'(r); init_offset = 10'(o);
        @(negedge clk);
        init_valid = 1'b0;
    endtask

    // Issue one request; feed the bit when asked, after 'stall' idle offers.
    task automatic run_req(input logic mode, input logic b, input int stall,
                           input logic poke_init, output int got, output int used,
                           output int lat);
        int waited;
        bit done;
        int r0, o0;
        waited = 0; done = 0; used = 0; lat = -1; got = -1; r0 = 0; o0 = 0;
        @(negedge clk);
        req_mode = mode; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (bin_valid) begin
                got = int'(bin_value); lat = c; done = 1;
                break;
            end
            bit_valid = 1'b0; init_valid = 1'b0;
            if (bit_ready) begin
                if (waited < stall) begin
                    if (waited == 0) begin
                        r0 = int'(cur_range); o0 = int'(cur_offset);
                        init_valid = poke_init; init_range = 9'd400; init_offset = 10'd7;
                    end
                    waited++;
                end else begin
                    if (stall > 0) begin
                        chk("R7 range held in stall", int'(cur_range), r0);
                        chk("R7 offset held in stall (R2 init ignored)", int'(cur_offset), o0);
                    end
                    bit_valid = 1'b1; bit_data = b; used++;
                end
            end
            @(negedge clk);
        end
        bit_valid = 1'b0; init_valid = 1'b0;
        if (!done) chk("R8 bin_valid never came", 0, 1);
        @(negedge clk);
        chk("R8 pulse one cycle", int'(bin_valid), 0);
        chk("R8 req_ready back", int'(req_ready), 1);
    endtask

    // Expected result from the requirements.
    task automatic model(input logic mode, input int r, input int o, input int b,
                         output int eb, output int er, output int eo, output int eu);
        int t;
        if (mode) begin
            t = r - 2;
            er = t; eo = o; eu = 0;
            if (o >= t) eb = 1;
            else begin
                eb = 0;
                if (t < 256) begin er = t * 2; eo = o * 2 + b; eu = 1; end
            end
        end else begin
            t = o * 2 + b; eu = 1; er = r;
            if (t >= r) begin eb = 1; eo = t - r; end
            else begin eb = 0; eo = t; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int got, used, lat, eb, er, eo, eu, r, o;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 range", int'(cur_range), 510);
        chk("R1 offset", int'(cur_offset), 0);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 bin_valid", int'(bin_valid), 0);
        chk("R1 bit_ready", int'(bit_ready), 0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            r = int'(VEC[i][19:11]); o = int'(VEC[i][10:1]);
            load(r, o);
            chk("R2 init range", int'(cur_range), r);
            chk("R2 init offset", int'(cur_offset), o);
            model(VEC[i][20], r, o, int'(VEC[i][0]), eb, er, eo, eu);
            if (!VEC[i][20]) tag = "R6";
            else if (eb == 1) tag = "R3";
            else if (eu == 1) tag = "R5";
            else tag = "R4";
            run_req(VEC[i][20], VEC[i][0], 0, 1'b0, got, used, lat);
            chk({tag, " bin"}, got, eb);
            chk({tag, " range"}, int'(cur_range), er);
            chk({tag, " offset"}, int'(cur_offset), eo);
            chk({tag, " bits used"}, used, eu);
            chk({tag, " latency"}, lat, eu);
        end

        // R2: init blocks request acceptance
        @(negedge clk);
        init_valid = 1'b1; init_range = 9'd300; init_offset = 10'd149;
        #1;
        chk("R2 req_ready low during init", int'(req_ready), 0);
        @(negedge clk);
        init_valid = 1'b0;

        // R7/R2: bypass stalled 3 cycles with an init strobe mid-request
        run_req(1'b0, 1'b1, 3, 1'b1, got, used, lat);
        chk("R6 stalled bin", got, 0);
        chk("R6 stalled offset", int'(cur_offset), 299);
        chk("R7 stalled latency", lat, 4);

        // R6: back-to-back bypass bins carry the offset
        run_req(1'b0, 1'b1, 0, 1'b0, got, used, lat);
        chk("R6 chain1 bin", got, 1);
        chk("R6 chain1 offset", int'(cur_offset), 299);
        run_req(1'b0, 1'b0, 0, 1'b0, got, used, lat);
        chk("R6 chain2 bin", got, 1);
        chk("R6 chain2 offset", int'(cur_offset), 298);
        chk("R6 chain2 range", int'(cur_range), 300);

        // R5/R7: terminal renormalization with a 2-cycle stall
        load(256, 10);
        run_req(1'b1, 1'b1, 2, 1'b0, got, used, lat);
        chk("R5 stalled bin", got, 0);
        chk("R5 stalled range", int'(cur_range), 508);
        chk("R5 stalled offset", int'(cur_offset), 21);
        chk("R7 renorm latency", lat, 3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule